// File: doc/BRIEF.md
# Serial (15,11) Cyclic Hamming Codec

This block holds two independent bit-serial channels for the (15,11) cyclic Hamming code generated by g(X) = 1 + X + X^4. The encoder channel takes eleven message bits, highest-order coefficient first. It forwards them unchanged and then appends four check bits. It forms those check bits in a four-stage dividing shift register, which it empties by plain shifting once the message is done.

The decoder channel takes fifteen received bits, first bit = coefficient of X^14. It divides them by g(X) into a syndrome register and stores the word at the same time. Once the word is complete, the block moves the word and the syndrome into a second stage, so that the next word can start arriving at once. The second stage sends the stored word out one bit per clock. Before each shift it checks whether the syndrome equals 1 + X^3, the value left by an error in the outgoing position. On a match it inverts that bit and feeds the correction back, which clears the register.

A start strobe marks the first bit of each word on both channels. The decoder pulses a corrected flag and a failure flag together with the last output bit of each word.

Top module: `hamm15_serial_codec`

## Requirements
- R1: Each encoder word is 15 accepted input bits. Output bits 1 to 11 equal the input message bits in the order given, and each appears on the clock after the bit was accepted, with `enc_out_valid` high.
- R2: Encoder output bits 12 to 15 are the coefficients of X^3, X^2, X^1 and X^0 of X^4·u(X) mod (1+X+X^4), in that order. The 15-bit output read with its first bit as X^14 is therefore a multiple of g(X).
- R3: `enc_din` has no effect during bit slots 12 to 15. `enc_out_first` is high only with the first output bit of a word.
- R4: On either channel, a start strobe accepted with valid begins a new word at bit 1 and discards any partial word.
- R5: With gap-free input, the first decoded bit appears 15 clocks after the first received bit. `dec_out_first` marks it, and the decoded bits leave in the order they were received.
- R6: A valid codeword leaves the decoder unchanged, with `dec_fixed` low.
- R7: A word with one inverted bit, at any of the 15 positions, is delivered corrected. `dec_fixed` is high on the cycle of its last output bit and low on every other cycle.
- R8: For a word with two inverted bits, the decoder also inverts the one position whose single-error syndrome equals the word's syndrome. `dec_fail` stays low, because every nonzero syndrome of this code matches one position.
- R9: Words may follow each other with no idle cycle on either channel. A valid-low cycle inside a word only pauses intake.
- R10: After reset, every output valid and flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid | input | 1 | Encoder input bit present |
| enc_start | input | 1 | Marks bit 1 of an encoder word |
| enc_din | input | 1 | Encoder input bit (message slots only) |
| enc_out_valid | output | 1 | Encoder output bit present |
| enc_out_first | output | 1 | First bit of an encoded word |
| enc_out_bit | output | 1 | Encoded output bit |
| dec_valid | input | 1 | Received bit present |
| dec_start | input | 1 | Marks bit 1 of a received word |
| dec_din | input | 1 | Received bit, X^14 first |
| dec_out_valid | output | 1 | Decoded bit present |
| dec_out_first | output | 1 | First bit of a decoded word |
| dec_out_bit | output | 1 | Decoded output bit |
| dec_fixed | output | 1 | Pulse with the last bit: a bit of this word was inverted |
| dec_fail | output | 1 | Pulse with the last bit: syndrome not cleared |

## Verification
The embedded properties assume one input condition. A received word may complete only once the previous word has at most one bit left to send, so the decoder's output stage never gets a new load while it is busy. The stimulus meets this in two ways. Back-to-back words arrive exactly fifteen accepted bits apart. Every other decoder word is either separated by idle cycles or stretched by valid-low pauses. Partial words are always dropped by a start strobe before their fifteenth bit.

// File: rtl/hamm15_serial_codec.sv
`timescale 1ns/1ps
module hamm15_serial_codec #(
  parameter int N = 15,
  parameter int P = 4,
  parameter logic [P-1:0] GLOW = 4'b0011,
  parameter logic [P-1:0] TOPSYN = 4'b1001
)(
  input  logic clk,
  input  logic rst_n,
  input  logic enc_valid,
  input  logic enc_start,
  input  logic enc_din,
  output logic enc_out_valid,
  output logic enc_out_first,
  output logic enc_out_bit,
  input  logic dec_valid,
  input  logic dec_start,
  input  logic dec_din,
  output logic dec_out_valid,
  output logic dec_out_first,
  output logic dec_out_bit,
  output logic dec_fixed,
  output logic dec_fail
);
  localparam int K  = N - P;
  localparam int CW = $clog2(N + 1);

  // encoder
  logic [CW-1:0] e_cnt, e_idx;
  logic [P-1:0]  e_rem, e_base;
  logic          e_msg, e_fb;

  assign e_idx  = enc_start ? '0 : e_cnt;
  assign e_base = (e_idx == '0) ? '0 : e_rem;
  assign e_msg  = e_idx < CW'(K);
  assign e_fb   = e_msg & (enc_din ^ e_base[P-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_cnt <= '0;
      e_rem <= '0;
      enc_out_valid <= 1'b0;
      enc_out_first <= 1'b0;
      enc_out_bit   <= 1'b0;
    end else begin
      enc_out_valid <= enc_valid;
      enc_out_first <= enc_valid && (e_idx == '0);
      if (enc_valid) begin
        enc_out_bit <= e_msg ? enc_din : e_base[P-1];
        e_rem <= {e_base[P-2:0], 1'b0} ^ (GLOW & {P{e_fb}});
        e_cnt <= (e_idx == CW'(N-1)) ? '0 : e_idx + 1'b1;
      end
    end
  end

  p_parity_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && e_idx == CW'(N-1)) |=> (e_rem == '0));
  p_first_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_first |-> enc_out_valid);

  // decoder intake
  logic [CW-1:0] d_cnt, d_idx;
  logic [N-2:0]  d_buf;
  logic [P-1:0]  d_syn, d_base, d_syn_nx;
  logic          d_load;

  assign d_idx    = dec_start ? '0 : d_cnt;
  assign d_base   = (d_idx == '0) ? '0 : d_syn;
  assign d_syn_nx = {d_base[P-2:0], dec_din} ^ (GLOW & {P{d_base[P-1]}});
  assign d_load   = dec_valid && (d_idx == CW'(N-1));

  // decoder output stage
  logic [CW-1:0] o_cnt;
  logic [N-1:0]  o_buf;
  logic [P-1:0]  o_syn, o_syn_nx;
  logic          o_act, o_hit, o_fixacc;

  assign o_act    = o_cnt != '0;
  assign o_hit    = o_act && (o_syn == TOPSYN);
  assign o_syn_nx = {o_syn[P-2:0], o_hit} ^ (GLOW & {P{o_syn[P-1]}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_cnt <= '0;
      d_syn <= '0;
      d_buf <= '0;
      o_cnt <= '0;
      o_buf <= '0;
      o_syn <= '0;
      o_fixacc <= 1'b0;
      dec_out_valid <= 1'b0;
      dec_out_first <= 1'b0;
      dec_out_bit   <= 1'b0;
      dec_fixed     <= 1'b0;
      dec_fail      <= 1'b0;
    end else begin
      dec_out_valid <= o_act;
      dec_out_first <= o_cnt == CW'(N);
      dec_out_bit   <= o_buf[N-1] ^ o_hit;
      dec_fixed     <= (o_cnt == CW'(1)) && (o_fixacc || o_hit);
      dec_fail      <= (o_cnt == CW'(1)) && (o_syn_nx != '0);
      if (dec_valid) begin
        d_cnt <= d_load ? '0 : d_idx + 1'b1;
        d_syn <= d_syn_nx;
        d_buf <= {d_buf[N-3:0], dec_din};
      end
      if (d_load) begin
        o_buf <= {d_buf, dec_din};
        o_syn <= d_syn_nx;
        o_cnt <= CW'(N);
        o_fixacc <= 1'b0;
      end else if (o_act) begin
        o_buf <= {o_buf[N-2:0], 1'b0};
        o_syn <= o_syn_nx;
        o_cnt <= o_cnt - 1'b1;
        o_fixacc <= o_fixacc || o_hit;
      end
    end
  end

  p_load_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    d_load |-> (o_cnt <= CW'(1)));
  p_hit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_hit && !d_load) |=> (o_syn == '0));
  p_first_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_first |-> dec_out_valid);
  p_fixed_on_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fixed |-> (dec_out_valid && !dec_out_first));
  p_no_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_fail);
endmodule

// File: tb/test_hamm15_serial_codec.sv
`timescale 1ns/1ps
module test_hamm15_serial_codec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_valid = 0, enc_start = 0, enc_din = 0;
  logic dec_valid = 0, dec_start = 0, dec_din = 0;
  logic enc_out_valid, enc_out_first, enc_out_bit;
  logic dec_out_valid, dec_out_first, dec_out_bit, dec_fixed, dec_fail;

  always #2.5 clk = ~clk;

  hamm15_serial_codec i_hamm15_serial_codec (
    .clk(clk), .rst_n(rst_n),
    .enc_valid(enc_valid), .enc_start(enc_start), .enc_din(enc_din),
    .enc_out_valid(enc_out_valid), .enc_out_first(enc_out_first), .enc_out_bit(enc_out_bit),
    .dec_valid(dec_valid), .dec_start(dec_start), .dec_din(dec_din),
    .dec_out_valid(dec_out_valid), .dec_out_first(dec_out_first), .dec_out_bit(dec_out_bit),
    .dec_fixed(dec_fixed), .dec_fail(dec_fail));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, started = 0;
  string escen = "", dscen = "R6";

  function automatic int rem15(int v);
    for (int i = 14; i >= 4; i--) if ((v >> i) & 1) v ^= 19 << (i - 4);
    return v & 15;
  endfunction
  function automatic int cword(int m);
    return (m << 4) | rem15(m << 4);
  endfunction

  task automatic chk(logic act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int ecnt = 0, emsg = 0, ecw = 0, eidx = 0;
  int dcnt = 0, dw = 0, dword = 0, dleft = 0, didx = 0;
  bit dfix = 0;
  string dtag = "";
  bit x_ev, x_ef, x_eb, x_dv, x_df, x_db, x_fix;
  string x_etag;

  always @(posedge clk) begin
    x_ev = 0; x_ef = 0; x_dv = 0; x_df = 0; x_fix = 0;
    if (!rst_n) begin
      ecnt = 0; dcnt = 0; dleft = 0;
    end else begin
      if (enc_valid) begin
        eidx = enc_start ? 0 : ecnt;
        if (eidx == 0) emsg = 0;
        if (eidx < 11) begin
          emsg = emsg * 2 + int'(enc_din);
          x_eb = enc_din;
          x_etag = {"R1", escen};
          if (eidx == 10) ecw = cword(emsg);
        end else begin
          x_eb = ((ecw >> (14 - eidx)) & 1) != 0;
          x_etag = {"R2,R3", escen};
        end
        x_ev = 1; x_ef = (eidx == 0);
        ecnt = (eidx == 14) ? 0 : eidx + 1;
      end
      if (dleft > 0) begin
        x_dv = 1;
        x_db = ((dword >> (dleft - 1)) & 1) != 0;
        x_df = (dleft == 15);
        if (dleft == 1) x_fix = dfix;
        dleft--;
      end
      if (dec_valid) begin
        didx = dec_start ? 0 : dcnt;
        if (didx == 0) dw = 0;
        dw = dw * 2 + int'(dec_din);
        if (didx == 14) begin
          int s;
          s = rem15(dw);
          dword = dw; dfix = 0;
          if (s != 0)
            for (int p = 0; p < 15; p++)
              if (rem15(1 << p) == s) begin dword = dw ^ (1 << p); dfix = 1; end
          dleft = 15; dtag = dscen;
        end
        dcnt = (didx == 14) ? 0 : didx + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && started) begin
    chk(enc_out_valid, x_ev, "R3 enc valid");
    if (x_ev) begin
      chk(enc_out_first, x_ef, {"R3 enc first", escen});
      chk(enc_out_bit, x_eb, x_etag);
    end
    chk(dec_out_valid, x_dv, {"R5 dec valid ", dtag});
    if (x_dv) begin
      chk(dec_out_first, x_df, {"R5 dec first ", dtag});
      chk(dec_out_bit, x_db, {"dec bit ", dtag});
    end
    chk(dec_fixed, x_fix, {"R7 fixed flag ", dtag});
    chk(dec_fail, 1'b0, "R8 fail flag");
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); enc_valid = 0; enc_start = 0; dec_valid = 0; dec_start = 0;
    end
  endtask

  task automatic enc_word(int msg, int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      enc_valid = 1; enc_start = (i == 0);
      enc_din = (i < 11) ? (((msg >> (10 - i)) & 1) != 0) : 1'($urandom % 2);
    end
  endtask

  task automatic dec_word(int w, int nbits, int gap_at);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (i == gap_at) begin dec_valid = 0; dec_start = 0; @(negedge clk); end
      dec_valid = 1; dec_start = (i == 0);
      dec_din = ((w >> (14 - i)) & 1) != 0;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int msgs [7] = '{0, 'h7FF, 'h555, 'h2AA, 1, 'h400, 'h123};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(enc_out_valid, 0, "R10"); chk(dec_out_valid, 0, "R10");
    chk(dec_fixed, 0, "R10"); chk(dec_fail, 0, "R10");
    rst_n = 1; started = 1;
    // encoder words, separated
    foreach (msgs[i]) begin enc_word(msgs[i], 15); idle(2); end
    escen = " R9";
    for (int i = 0; i < 4; i++) enc_word(msgs[i + 2], 15);
    idle(2);
    escen = " R4";
    enc_word('h3C1, 6); enc_word('h0F0, 15); idle(3);
    escen = "";
    // decoder: clean words
    dscen = "R6";
    foreach (msgs[i]) begin dec_word(cword(msgs[i]), 15, -1); idle(17); end
    // single errors at every position
    dscen = "R7";
    for (int p = 0; p < 15; p++) begin dec_word(cword('h5A3) ^ (1 << p), 15, -1); idle(16); end
    dec_word(1 << 14, 15, -1); idle(16);
    // double errors
    dscen = "R8";
    dec_word(cword('h1B4) ^ 3, 15, -1); idle(16);
    dec_word(cword('h6D2) ^ (1 << 14) ^ (1 << 7), 15, -1); idle(16);
    dec_word(cword('h0) ^ (1 << 9) ^ (1 << 2), 15, -1); idle(16);
    // back-to-back and pauses
    dscen = "R9";
    dec_word(cword('h111), 15, -1);
    dec_word(cword('h222) ^ (1 << 3), 15, -1);
    dec_word(cword('h7AB) ^ (1 << 14), 15, -1);
    dec_word(cword('h3C3) ^ 1, 15, -1);
    idle(16);
    dec_word(cword('h4E7) ^ (1 << 11), 15, 7); idle(17);
    // restart mid word
    dscen = "R4";
    dec_word(cword('h7FF), 9, -1);
    dec_word(cword('h29A) ^ (1 << 5), 15, -1); idle(20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule